// File: doc/BRIEF.md
# Strobed Serial Clock and Data Capture

This block receives a serial bit stream that comes with its own clock from outside the chip, at rates from tens of kilobits to a few megabits per second. It never uses the external clock pin as a clock. Both the clock pin and the data pin are treated as asynchronous levels. Each one passes through a flip-flop synchronizer into the fast internal clock domain. A rising-edge detector turns the synchronized clock into a strobe that lasts one internal cycle. On that strobe the synchronized data level is shifted into a word assembler. Every finished word is presented with a one-cycle valid pulse.

The internal clock has to run well above the bit rate, roughly ten times or more. A cable may be unplugged or replugged at any moment, so a watchdog counts internal cycles since the last bit. When the count exceeds a limit that software sets, the watchdog raises a clock-lost flag and throws away the partly built word. The next word after the link returns then starts on a clean boundary. No state of the block can be reached through the external clock pin except by way of the strobe, so nothing can lock up.

Top module: `serial_capture`

## Requirements
- R1: While reset is active, and on the cycles after its release before any bit arrives, `word_valid_o` is 0, `word_o` is 0 and `clk_lost_o` is 0.
- R2: Each low-to-high transition of `ext_clk_i` that holds for at least two internal cycles delivers exactly one bit. That bit is the level `ext_dat_i` had at the same internal sample that first saw the clock high, because both pins go through synchronizers of the same depth.
- R3: Words are assembled most significant bit first: the first bit received ends up in bit position WORD_W-1 of `word_o`.
- R4: `word_valid_o` is a single-cycle pulse. It rises after the third internal clock edge counted from the edge that first samples the last rising external clock of a word. `word_o` keeps that word until the next one completes.
- R5: A falling edge, or an external clock held high for any length of time, produces no bit.
- R6: Let `idle_limit_i` be L. If no bit is taken on L+1 internal edges in a row after the edge that took a bit, `clk_lost_o` goes to 1 on the (L+1)th of those edges.
- R7: When `clk_lost_o` goes to 1, the bits already collected for the current word are discarded, and the next bit received becomes the most significant bit of a new word.
- R8: `clk_lost_o` returns to 0 on the internal edge that takes the next bit.
- R9: Capture still works when the external clock is high for two internal cycles and low for two internal cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| ext_clk_i | input | 1 | External bit clock, asynchronous |
| ext_dat_i | input | 1 | External serial data, asynchronous |
| idle_limit_i | input | LIMIT_W | Number of idle internal cycles allowed before the link is declared lost |
| word_o | output | WORD_W | Last assembled word, most significant bit first on the wire |
| word_valid_o | output | 1 | One-cycle pulse when `word_o` updates |
| clk_lost_o | output | 1 | External clock missing for longer than the limit |

## Verification
Every rising external clock reaches the registered outputs three internal edges after it is first sampled: two edges pass through the synchronizer and one updates the assembler. Each time the driver raises the last bit of a word, it records the cycle number at which the valid pulse must appear, together with the word. The monitor then demands the pulse in exactly that cycle and no other. For the lost flag, the bench counts from the edge that took the last bit. It samples one cycle before and one cycle at the expected rise for two different limits, then confirms that the flag clears and that the next word arrives intact.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_WORD_W      = 8;
  localparam int unsigned DEF_LIMIT_W     = 16;

  // Width of a counter that must hold values 0..n-1
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rise_strobe.sv
module rise_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic strobe_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign strobe_o = level_i & ~prev_q;
endmodule

// File: rtl/word_assembler.sv
module word_assembler #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              bit_i,
  input  logic              flush_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  import cap_pkg::*;
  localparam int unsigned CNT_W = idx_w(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shift_q, shift_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              valid_q, valid_d;
  logic              shift_en, word_en;

  always_comb begin
    shift_d  = shift_q;
    cnt_d    = cnt_q;
    word_d   = word_q;
    valid_d  = 1'b0;
    shift_en = 1'b0;
    word_en  = 1'b0;
    if (flush_i) begin
      shift_en = 1'b1;
      shift_d  = '0;
      cnt_d    = '0;
    end else if (strobe_i) begin
      shift_en = 1'b1;
      shift_d  = {shift_q[WORD_W-2:0], bit_i};
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        word_en = 1'b1;
        word_d  = {shift_q[WORD_W-2:0], bit_i};
        valid_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (shift_en) begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/link_watchdog.sv
module link_watchdog #(
  parameter int unsigned LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               lost_o,
  output logic               flush_o
);
  logic [LIMIT_W-1:0] cnt_q, cnt_d;
  logic               lost_q, lost_d;
  logic               cnt_en;
  logic               expired;

  assign expired = (cnt_q >= limit_i);

  always_comb begin
    cnt_d  = cnt_q;
    lost_d = lost_q;
    cnt_en = 1'b0;
    if (strobe_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
      lost_d = 1'b0;
    end else if (expired) begin
      lost_d = 1'b1;
    end else begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lost_q <= 1'b0;
    else        lost_q <= lost_d;
  end

  assign lost_o  = lost_q;
  assign flush_o = ~strobe_i & expired & ~lost_q;
endmodule

// File: rtl/serial_capture.sv
module serial_capture
  import cap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned WORD_W      = DEF_WORD_W,
  parameter int unsigned LIMIT_W     = DEF_LIMIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_clk_i,
  input  logic               ext_dat_i,
  input  logic [LIMIT_W-1:0] idle_limit_i,
  output logic [WORD_W-1:0]  word_o,
  output logic               word_valid_o,
  output logic               clk_lost_o
);
  logic rst_n_q;
  logic clk_lvl;
  logic dat_lvl;
  logic bit_stb;
  logic flush;

  // Reset asserts at once, releases on a clock edge
  bit_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_n_q)
  );

  bit_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
    .clk(clk), .rst_n(rst_n_q), .d_i(ext_clk_i), .q_o(clk_lvl)
  );

  // Same depth as the clock path keeps data aligned with its strobe
  bit_sync #(.STAGES(SYNC_STAGES)) u_dat_sync (
    .clk(clk), .rst_n(rst_n_q), .d_i(ext_dat_i), .q_o(dat_lvl)
  );

  rise_strobe u_edge (
    .clk(clk), .rst_n(rst_n_q), .level_i(clk_lvl), .strobe_o(bit_stb)
  );

  link_watchdog #(.LIMIT_W(LIMIT_W)) u_dog (
    .clk(clk), .rst_n(rst_n_q), .strobe_i(bit_stb), .limit_i(idle_limit_i),
    .lost_o(clk_lost_o), .flush_o(flush)
  );

  word_assembler #(.WORD_W(WORD_W)) u_asm (
    .clk(clk), .rst_n(rst_n_q), .strobe_i(bit_stb), .bit_i(dat_lvl),
    .flush_i(flush), .word_o(word_o), .valid_o(word_valid_o)
  );
endmodule

// File: rtl/capture_checker.sv
module capture_checker #(
  parameter int unsigned LIMIT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               int_rst_n,
  input logic               ext_clk_i,
  input logic               bit_stb,
  input logic [LIMIT_W-1:0] idle_limit_i,
  input logic               word_valid_o,
  input logic               clk_lost_o
);
  logic [LIMIT_W:0] gap_q;
  logic [1:0]       age_q;

  always_ff @(posedge clk or negedge int_rst_n) begin
    if (!int_rst_n) begin
      gap_q <= '0;
      age_q <= '0;
    end else begin
      if (bit_stb)       gap_q <= '0;
      else if (~&gap_q)  gap_q <= gap_q + 1'b1;
      if (age_q != 2'd3) age_q <= age_q + 1'b1;
    end
  end

  // R1: outputs quiet while reset is held
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      a_reset_quiet_r1: assert (word_valid_o == 1'b0 && clk_lost_o == 1'b0);
    end
  end

  // R2: a strobe is one cycle wide
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!int_rst_n)
    bit_stb |=> !bit_stb);

  // R2/R5: a strobe comes only from a low-to-high change on the pin
  p_strobe_source_r2: assert property (@(posedge clk) disable iff (!int_rst_n)
    (bit_stb && age_q == 2'd3) |-> ($past(ext_clk_i, 2) && !$past(ext_clk_i, 3)));

  // R4: valid is a single-cycle pulse
  p_valid_single_r4: assert property (@(posedge clk) disable iff (!int_rst_n)
    word_valid_o |=> !word_valid_o);

  // R6: flag rises once the idle gap passes the limit
  p_lost_raise_r6: assert property (@(posedge clk) disable iff (!int_rst_n)
    (!bit_stb && gap_q == {1'b0, idle_limit_i}) |=> clk_lost_o);

  // R8: a taken bit clears the flag
  p_lost_clear_r8: assert property (@(posedge clk) disable iff (!int_rst_n)
    bit_stb |=> !clk_lost_o);
endmodule

bind serial_capture capture_checker #(.LIMIT_W(LIMIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_rst_n(rst_n_q), .ext_clk_i(ext_clk_i),
  .bit_stb(bit_stb), .idle_limit_i(idle_limit_i),
  .word_valid_o(word_valid_o), .clk_lost_o(clk_lost_o)
);

// File: tb/serial_capture_bench.sv
module serial_capture_bench;
  localparam int LIMIT_W = 16;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               ext_clk = 1'b0;
  logic               ext_dat = 1'b0;
  logic [LIMIT_W-1:0] limit = 16'd20;
  logic [7:0]         word;
  logic               valid;
  logic               lost;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] data; int due; } exp_t;
  exp_t sb[$];

  serial_capture u_serial_capture (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .ext_dat_i(ext_dat),
    .idle_limit_i(limit), .word_o(word), .word_valid_o(valid), .clk_lost_o(lost)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R4 unexpected valid", int'(word), -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(word == e.data, "R3 word value", int'(word), int'(e.data));
        check(cyc == e.due, "R4 valid cycle", cyc, e.due);
      end
    end
  end

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Low phase, then rise with data changing at the same moment (R2)
  task automatic send_bit(input logic b, input int lo, output int rise);
    ext_clk = 1'b0;
    hold(lo);
    ext_clk = 1'b1;
    ext_dat = b;
    rise = cyc;
  endtask

  task automatic send_word(input logic [7:0] w, input int lo, input int hi);
    int r;
    for (int i = 7; i >= 0; i--) begin
      send_bit(w[i], lo, r);
      if (i == 0) sb.push_back('{data: w, due: r + 3});
      hold(hi);
    end
    ext_clk = 1'b0;
  endtask

  task automatic do_reset(input logic [LIMIT_W-1:0] lim);
    @(negedge clk);
    rst_n = 1'b0;
    ext_clk = 1'b0;
    ext_dat = 1'b0;
    limit = lim;
    hold(3);
    check(valid == 1'b0 && lost == 1'b0, "R1 in reset", {valid, lost}, 0);
    rst_n = 1'b1;
    hold(4);
    check(word == 8'h00, "R1 word after reset", int'(word), 0);
    check(valid == 1'b0, "R1 valid after reset", int'(valid), 0);
    check(lost == 1'b0, "R1 lost after reset", int'(lost), 0);
  endtask

  task automatic stall_case(input logic [LIMIT_W-1:0] lim);
    int r;
    int r1;
    logic [7:0] w;
    do_reset(lim);
    send_bit(1'b1, 6, r); hold(6);
    send_bit(1'b0, 6, r); hold(6);
    send_bit(1'b1, 6, r);
    // clock stays high: no further bits (R5)
    wait_until(r + 3 + int'(lim));
    check(lost == 1'b0, "R6 not yet lost", int'(lost), 0);
    @(negedge clk);
    check(lost == 1'b1, "R6 lost raised", int'(lost), 1);
    check(valid == 1'b0, "R5 no word from held clock", int'(valid), 0);
    hold(10);
    w = 8'h5A ^ lim[7:0];
    send_bit(w[7], 6, r1);
    wait_until(r1 + 2);
    check(lost == 1'b1, "R8 still lost before bit", int'(lost), 1);
    @(negedge clk);
    check(lost == 1'b0, "R8 cleared by bit", int'(lost), 0);
    hold(3);
    for (int i = 6; i >= 0; i--) begin
      send_bit(w[i], 6, r);
      if (i == 0) sb.push_back('{data: w, due: r + 3});
      hold(6);
    end
    ext_clk = 1'b0;
    hold(8);
    check(sb.size() == 0, "R7 fresh word after flush", sb.size(), 0);
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    do_reset(16'd20);
    // R3/R4: several patterns at 12 cycles per bit
    send_word(8'hA5, 6, 6);
    send_word(8'h3C, 6, 6);
    send_word(8'hFF, 6, 6);
    send_word(8'h00, 6, 6);
    send_word(8'h81, 6, 6);
    hold(8);
    // R9: fastest rate, 2 high / 2 low
    send_word(8'hC3, 2, 2);
    send_word(8'h01, 2, 2);
    send_word(8'h7E, 2, 2);
    hold(8);
    check(sb.size() == 0, "R9 all fast words seen", sb.size(), 0);
    // R6/R7/R8 with two limits
    stall_case(16'd20);
    stall_case(16'd35);
    hold(5);
    check(sb.size() == 0, "R4 no missing words", sb.size(), 0);
    finish_run();
  end
endmodule